// File: doc/BRIEF.md
# CAN Controller Low-Power Mode Sequencer

This block governs the two reduced-activity modes of a CAN protocol controller: sleep and suspend. Software asks for a mode by setting a request bit in the mode control register. The sequencer does not switch modes in the middle of bus traffic. It holds the request until the frame in progress, or a bus-off recovery, has finished. It then raises the matching status bit and takes the controller off the bus through a bus-disable output.

While asleep, the sequencer clears the error counters and the transmit request bits through level outputs. It replaces every register read with a fixed status word for the status register, and with zero for every other register. It also blocks every register write except a write to the mode control register. Two events wake the block: a write to the mode control register, or a dominant bit on the bus when wake-on-bus-activity is enabled. After either event the block pulses a clear for the sleep request bit. It then keeps the controller off the bus until it has seen a run of consecutive recessive bits, so the frame that caused the wake-up is never taken as valid.

Suspend keeps the controller silent on the bus, with no error frames and no acknowledge. The error state is kept, so no clear output is driven. Suspend ends as soon as its request bit reads 0. All pins are plain control and status levels or strobes. The block has no streamed data path and no handshake.

Top module: `can_lp_seq`

## Requirements
- R1: After reset, sleep_act_o, susp_act_o, bus_dis_o, clr_err_o, clr_txreq_o and sleep_req_clr_o are all 0. Outside sleep, rd_data_o equals rd_data_i and wr_en_o equals wr_en_i.
- R2: A sleep request made while bus_idle_i is 1 sets sleep_act_o on the second rising edge that samples the request. Once asleep, bus_dis_o is 1.
- R3: While a sleep request waits on a busy bus (bus_idle_i=0), entry happens on the edge that samples tx_done_i, or rx_done_i after an arb_lost_i seen during the wait. A rx_done_i without a prior arbitration loss does not cause entry.
- R4: While asleep, rd_data_o is SLEEP_STATUS (0x0001F040 by default) when rd_status_sel_i is 1, and 0 otherwise.
- R5: While asleep, wr_en_o is 1 only when wr_en_i and wr_mode_sel_i are both 1.
- R6: clr_err_o and clr_txreq_o are 1 throughout sleep and 0 in suspend and in active operation.
- R7: In sleep, a write with wr_mode_sel_i=1 wakes the block on the edge that samples it. So does a bit_tick_i with rx_i=0, but only when wake_on_bus_i is 1. On wake, sleep_act_o drops and sleep_req_clr_o is 1 for exactly one cycle.
- R8: After wake, bus_dis_o stays 1 until RECESSIVE_BITS consecutive bit_tick_i samples with rx_i=1 have been seen. A sample with rx_i=0 restarts the count. bus_dis_o falls one cycle after the last recessive sample.
- R9: Suspend entry waits until bus_idle_i=1 and busoff_rec_i=0. susp_act_o then rises on that edge, with bus_dis_o=1.
- R10: While suspended, a suspend_req_i of 0 (and no sleep request) clears susp_act_o and bus_dis_o on the next edge.
- R11: When sleep and suspend are requested together, sleep wins and susp_act_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Sleep request bit from the mode control register |
| suspend_req_i | input | 1 | Suspend request bit from the mode control register |
| wake_on_bus_i | input | 1 | Enables wake-up on dominant bus activity |
| tx_done_i | input | 1 | Strobe: transmit completed successfully |
| rx_done_i | input | 1 | Strobe: receive completed successfully |
| arb_lost_i | input | 1 | Strobe: arbitration lost |
| bus_idle_i | input | 1 | Bus currently idle |
| busoff_rec_i | input | 1 | Bus-off recovery in progress |
| bit_tick_i | input | 1 | One-cycle strobe at each bit sample point |
| rx_i | input | 1 | Sampled RX line, 1 = recessive |
| rd_status_sel_i | input | 1 | Current read addresses the global status register |
| rd_data_i | input | DATA_W | Read data from the register file |
| rd_data_o | output | DATA_W | Read data after sleep masking |
| wr_en_i | input | 1 | Register write request |
| wr_mode_sel_i | input | 1 | Current write addresses the mode control register |
| wr_en_o | output | 1 | Register write enable after sleep blocking |
| sleep_act_o | output | 1 | Sleep-active status bit |
| susp_act_o | output | 1 | Suspend-active status bit |
| bus_dis_o | output | 1 | Holds the controller off the bus |
| clr_err_o | output | 1 | Clears the error counters |
| clr_txreq_o | output | 1 | Clears the transmit request set and reset bits |
| sleep_req_clr_o | output | 1 | One-cycle clear of the sleep request bit on wake-up |

## Verification
The bench builds the block with DATA_W=16, SLEEP_STATUS=16'hF040 and RECESSIVE_BITS=4. The short recessive run lets the bench sweep every position of a dominant bit inside the wake-up window, and each sweep restarts the count. It also reaches the saturation boundary in a handful of cycles. The bench walks all four sleep-entry event kinds on a busy bus. It also covers every combination of the read select and write select while asleep.

// File: rtl/can_lp_pkg.sv
package can_lp_pkg;
  typedef enum logic [2:0] {
    LP_ACTIVE     = 3'd0,
    LP_SLEEP_PEND = 3'd1,
    LP_SLEEP      = 3'd2,
    LP_WAKE_WAIT  = 3'd3,
    LP_SUSP_PEND  = 3'd4,
    LP_SUSP       = 3'd5
  } lp_state_e;
endpackage

// File: rtl/can_lp_wake_cnt.sv
module can_lp_wake_cnt #(
  parameter int RECESSIVE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  input  logic rx_i,
  output logic done_o
);
  localparam int CW = $clog2(RECESSIVE_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(RECESSIVE_BITS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear_i)      cnt_q <= '0;
    else if (tick_i) begin
      if (!rx_i)           cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q == FULL);

  // R8
  dominant_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !rx_i) |=> (cnt_q == '0));
endmodule

// File: rtl/can_lp_reg_gate.sv
module can_lp_reg_gate #(
  parameter int              DATA_W       = 32,
  parameter logic [DATA_W-1:0] SLEEP_STATUS = 32'h0001F040
) (
  input  logic              asleep_i,
  input  logic              rd_status_sel_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic              wr_mode_sel_i,
  output logic              wr_en_o
);
  always_comb begin
    if (asleep_i) rd_data_o = rd_status_sel_i ? SLEEP_STATUS : '0;
    else          rd_data_o = rd_data_i;
  end

  assign wr_en_o = wr_en_i && (!asleep_i || wr_mode_sel_i);
endmodule

// File: rtl/can_lp_fsm.sv
module can_lp_fsm
  import can_lp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req_i,
  input  logic suspend_req_i,
  input  logic tx_done_i,
  input  logic rx_done_i,
  input  logic arb_lost_i,
  input  logic bus_idle_i,
  input  logic busoff_rec_i,
  input  logic wake_i,
  input  logic quiet_done_i,
  output lp_state_e state_o,
  output logic sleep_req_clr_o
);
  lp_state_e state_q, state_d;
  logic      arb_seen_q;
  logic      clr_q;
  logic      frame_end;

  assign frame_end = bus_idle_i || tx_done_i ||
                     ((arb_seen_q || arb_lost_i) && rx_done_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LP_ACTIVE: begin
        if (sleep_req_i)        state_d = LP_SLEEP_PEND;
        else if (suspend_req_i) state_d = LP_SUSP_PEND;
      end
      LP_SLEEP_PEND: begin
        if (!sleep_req_i)       state_d = LP_ACTIVE;
        else if (frame_end)     state_d = LP_SLEEP;
      end
      LP_SLEEP: begin
        if (wake_i)             state_d = LP_WAKE_WAIT;
      end
      LP_WAKE_WAIT: begin
        if (quiet_done_i)       state_d = LP_ACTIVE;
      end
      LP_SUSP_PEND: begin
        if (sleep_req_i)        state_d = LP_SLEEP_PEND;
        else if (!suspend_req_i) state_d = LP_ACTIVE;
        else if (bus_idle_i && !busoff_rec_i) state_d = LP_SUSP;
      end
      LP_SUSP: begin
        if (sleep_req_i)        state_d = LP_SLEEP;
        else if (!suspend_req_i) state_d = LP_ACTIVE;
      end
      default:                  state_d = LP_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LP_ACTIVE;
      arb_seen_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      arb_seen_q <= (state_q == LP_SLEEP_PEND) && (arb_seen_q || arb_lost_i);
      clr_q      <= (state_q == LP_SLEEP) && wake_i;
    end
  end

  assign state_o         = state_q;
  assign sleep_req_clr_o = clr_q;

  // R2
  sleep_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != LP_SLEEP && state_d == LP_SLEEP) |-> sleep_req_i);

  // R9
  susp_entry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LP_SUSP_PEND && state_d == LP_SUSP) |-> (bus_idle_i && !busoff_rec_i));

  // R10
  susp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LP_SUSP && !suspend_req_i && !sleep_req_i) |=> (state_q == LP_ACTIVE));

  // R11
  sleep_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LP_ACTIVE && sleep_req_i && suspend_req_i) |=> (state_q == LP_SLEEP_PEND));

  // R7
  wake_clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req_clr_o |=> !sleep_req_clr_o);
endmodule

// File: rtl/can_lp_seq.sv
module can_lp_seq
  import can_lp_pkg::*;
#(
  parameter int                DATA_W         = 32,
  parameter logic [DATA_W-1:0] SLEEP_STATUS   = 32'h0001F040,
  parameter int                RECESSIVE_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req_i,
  input  logic              suspend_req_i,
  input  logic              wake_on_bus_i,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              arb_lost_i,
  input  logic              bus_idle_i,
  input  logic              busoff_rec_i,
  input  logic              bit_tick_i,
  input  logic              rx_i,
  input  logic              rd_status_sel_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic              wr_mode_sel_i,
  output logic              wr_en_o,
  output logic              sleep_act_o,
  output logic              susp_act_o,
  output logic              bus_dis_o,
  output logic              clr_err_o,
  output logic              clr_txreq_o,
  output logic              sleep_req_clr_o
);
  lp_state_e state;
  logic      asleep, wake, quiet_done;

  assign asleep = (state == LP_SLEEP);
  assign wake   = (wr_en_i && wr_mode_sel_i) ||
                  (wake_on_bus_i && bit_tick_i && !rx_i);

  can_lp_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .sleep_req_i     (sleep_req_i),
    .suspend_req_i   (suspend_req_i),
    .tx_done_i       (tx_done_i),
    .rx_done_i       (rx_done_i),
    .arb_lost_i      (arb_lost_i),
    .bus_idle_i      (bus_idle_i),
    .busoff_rec_i    (busoff_rec_i),
    .wake_i          (wake),
    .quiet_done_i    (quiet_done),
    .state_o         (state),
    .sleep_req_clr_o (sleep_req_clr_o)
  );

  can_lp_wake_cnt #(.RECESSIVE_BITS(RECESSIVE_BITS)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (state != LP_WAKE_WAIT),
    .tick_i  (bit_tick_i),
    .rx_i    (rx_i),
    .done_o  (quiet_done)
  );

  can_lp_reg_gate #(.DATA_W(DATA_W), .SLEEP_STATUS(SLEEP_STATUS)) u_gate (
    .asleep_i        (asleep),
    .rd_status_sel_i (rd_status_sel_i),
    .rd_data_i       (rd_data_i),
    .rd_data_o       (rd_data_o),
    .wr_en_i         (wr_en_i),
    .wr_mode_sel_i   (wr_mode_sel_i),
    .wr_en_o         (wr_en_o)
  );

  assign sleep_act_o = asleep;
  assign susp_act_o  = (state == LP_SUSP);
  assign bus_dis_o   = asleep || (state == LP_WAKE_WAIT) || (state == LP_SUSP);
  assign clr_err_o   = asleep;
  assign clr_txreq_o = asleep;

  // R8
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_WAKE_WAIT && !quiet_done) |=> bus_dis_o);
endmodule

// File: tb/test_can_lp_seq.sv
module test_can_lp_seq;
  localparam int DW = 16;
  localparam int RB = 4;
  localparam logic [DW-1:0] STAT = 16'hF040;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, susp_req = 0, wob = 0, tx_done = 0, rx_done = 0, arb = 0;
  logic idle = 1, bor = 0, tick = 0, rx = 1, rd_sel = 0, wr_en = 0, wr_mode = 0;
  logic [DW-1:0] rd_in = 16'hABCD, rd_out;
  logic wr_out, s_act, u_act, bdis, c_err, c_tx, s_clr;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  can_lp_seq #(.DATA_W(DW), .SLEEP_STATUS(STAT), .RECESSIVE_BITS(RB)) i_can_lp_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .suspend_req_i(susp_req),
    .wake_on_bus_i(wob), .tx_done_i(tx_done), .rx_done_i(rx_done), .arb_lost_i(arb),
    .bus_idle_i(idle), .busoff_rec_i(bor), .bit_tick_i(tick), .rx_i(rx),
    .rd_status_sel_i(rd_sel), .rd_data_i(rd_in), .rd_data_o(rd_out),
    .wr_en_i(wr_en), .wr_mode_sel_i(wr_mode), .wr_en_o(wr_out),
    .sleep_act_o(s_act), .susp_act_o(u_act), .bus_dis_o(bdis),
    .clr_err_o(c_err), .clr_txreq_o(c_tx), .sleep_req_clr_o(s_clr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_in(logic v);
    tick = 1; rx = v; cyc(); tick = 0; rx = 1;
  endtask

  task automatic enter_sleep();
    idle = 1; sleep_req = 1; cyc(2);
  endtask

  task automatic wake_mcr_and_quiet();
    wr_en = 1; wr_mode = 1; cyc(); wr_en = 0; wr_mode = 0; sleep_req = 0;
    for (int i = 0; i < RB; i++) bit_in(1'b1);
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc();
    // R1 reset state and pass-through
    chk("R1 status", {s_act, u_act, bdis, c_err, c_tx, s_clr}, 0);
    rd_sel = 1; #1 chk("R1 read pass", rd_out, 16'hABCD);
    wr_en = 1; #1 chk("R1 write pass", wr_out, 1); wr_en = 0; rd_sel = 0;

    // R2 idle entry timing
    idle = 1; sleep_req = 1; cyc();
    chk("R2 one edge", s_act, 0);
    cyc();
    chk("R2 asleep", s_act, 1);
    chk("R2 bus off", bdis, 1);
    chk("R6 clears in sleep", {c_err, c_tx}, 2'b11);

    // R4 / R5 sweeps while asleep
    for (int s = 0; s < 2; s++) begin
      rd_sel = s[0]; #1;
      chk("R4 masked read", rd_out, s[0] ? STAT : 0);
    end
    rd_sel = 0;
    for (int w = 0; w < 4; w++) begin
      wr_en = w[0]; wr_mode = w[1]; #1;
      chk("R5 write gate", wr_out, w[0] & w[1]);
      wr_en = 0; wr_mode = 0; #1;
    end
    chk("R5 still asleep", s_act, 1);

    // R7 wake by mode write
    wr_en = 1; wr_mode = 1; cyc(); wr_en = 0; wr_mode = 0;
    chk("R7 awake", s_act, 0);
    chk("R7 clr pulse", s_clr, 1);
    sleep_req = 0; cyc();
    chk("R7 clr single", s_clr, 0);

    // R8 dominant at each position restarts count
    for (int p = 0; p < RB; p++) begin
      for (int i = 0; i < p; i++) bit_in(1'b1);
      bit_in(1'b0);
      chk("R8 restart", bdis, 1);
    end
    for (int i = 0; i < RB - 1; i++) bit_in(1'b1);
    chk("R8 short run", bdis, 1);
    bit_in(1'b1);
    chk("R8 last sample", bdis, 1);
    cyc();
    chk("R8 released", bdis, 0);

    // R7 wake on bus activity
    enter_sleep();
    wob = 0; bit_in(1'b0);
    chk("R7 no wake when disabled", s_act, 1);
    wob = 1; rx = 0; cyc(); rx = 1;
    chk("R7 no wake without tick", s_act, 1);
    bit_in(1'b0);
    chk("R7 bus wake", s_act, 0);
    chk("R7 bus wake clr", s_clr, 1);
    wob = 0; sleep_req = 0;
    for (int i = 0; i < RB; i++) bit_in(1'b1);
    cyc();
    chk("R8 released after bus wake", bdis, 0);

    // R3 entry events on a busy bus
    for (int k = 0; k < 4; k++) begin
      idle = 0; sleep_req = 1; cyc(2);
      chk("R3 waits", s_act, 0);
      if (k == 1 || k == 3) begin arb = 1; cyc(); arb = 0; end
      if (k == 0 || k == 3) tx_done = 1; else rx_done = 1;
      cyc(); tx_done = 0; rx_done = 0;
      chk("R3 event entry", s_act, (k != 2));
      if (k == 2) begin idle = 1; cyc(); chk("R3 idle entry", s_act, 1); end
      wake_mcr_and_quiet();
      chk("R3 back active", bdis, 0);
    end

    // R9 suspend entry
    idle = 0; susp_req = 1; cyc(2);
    chk("R9 busy wait", u_act, 0);
    idle = 1; bor = 1; cyc();
    chk("R9 recovery wait", u_act, 0);
    bor = 0; cyc();
    chk("R9 suspended", {u_act, bdis}, 2'b11);
    chk("R6 no clear in suspend", {c_err, c_tx}, 0);
    // R10 exit
    susp_req = 0; cyc();
    chk("R10 exit", {u_act, bdis}, 0);

    // R11 priority
    sleep_req = 1; susp_req = 1; cyc(2);
    chk("R11 sleep wins", {s_act, u_act}, 2'b10);
    susp_req = 0;
    wake_mcr_and_quiet();
    chk("R11 recovered", {s_act, u_act, bdis}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule